// File: doc/BRIEF.md
# Delayed Write Request Tracker

This block manages non-posted single-DWord writes (I/O writes and both kinds of configuration write) that must cross a bridge. When such a write is first attempted on the originating side, the block tells the originator to retry. In the same cycle it captures the request into its only queue slot. It then presents the captured request on the destination port and keeps it there until the destination reports completion. The completion status is held in the slot. When the originator repeats the identical request, the block accepts that attempt and returns the held status, and the slot becomes free again.

The slot can hold one request at a time. Any other queued-type request that arrives while the slot is in use is retried. If a completed request is never collected, a discard timer frees the slot after a set number of cycles. A configuration write of the local kind that arrives on the near-side interface is addressed to the bridge's own registers. It bypasses the slot: it is accepted at once and comes out as a one-cycle register-write strobe.

Top module: `dwr_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rsp_valid, rsp_retry, rsp_accept, dst_req and cfg_we are all low.
- R2: The command codes are 2'b01 for an I/O write, 2'b10 for a local configuration write and 2'b11 for a forwarded configuration write. A queued-type attempt (any attempt except a local configuration write with org_near high) that arrives while the slot is empty is retried. It is also captured, and from the next cycle dst_req is high with dst_cmd, dst_addr, dst_data and dst_be equal to the captured values.
- R3: dst_req stays high with stable request fields until dst_done is sampled high. dst_status at that edge becomes the held completion status.
- R4: While the slot is occupied, a queued-type attempt that differs from the held request is retried and does not change the held request.
- R5: A repeat of the held request made before the destination has completed is retried.
- R6: A repeat of the held request made after destination completion is accepted with rsp_status equal to the held status. dst_req stays low afterwards, and the slot is free, so the next queued-type attempt is captured as a new request.
- R7: A repeat counts as a match only if command, address, data and byte enables are all equal. A difference in any one of them causes a retry.
- R8: After completion, the slot stays held for DISCARD_CYCLES clock edges. An exact repeat sampled at the last of those edges is accepted. If no exact repeat arrives within that window, the slot is freed, and a later repeat is treated as a new request.
- R9: A local configuration write (command 2'b10) with org_near high is accepted with rsp_status 2'b00. In the next cycle cfg_we pulses with the request's address, data and byte enables. It has no effect on the slot.
- R10: Every attempt gets exactly one response, one cycle later: rsp_valid is high with exactly one of rsp_retry and rsp_accept set. No response is given without an attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_valid | input | 1 | One-cycle attempt strobe from the originating side |
| org_near | input | 1 | Attempt arrived on the near-side interface |
| org_cmd | input | 2 | Write command code |
| org_addr | input | AW | Write address |
| org_data | input | DW | Write data word |
| org_be | input | DW/8 | Byte enables |
| rsp_valid | output | 1 | Response to the previous cycle's attempt |
| rsp_retry | output | 1 | Attempt must be repeated |
| rsp_accept | output | 1 | Attempt completed |
| rsp_status | output | 2 | Completion status returned with an accept |
| dst_req | output | 1 | Request presented on the destination side |
| dst_cmd | output | 2 | Held command |
| dst_addr | output | AW | Held address |
| dst_data | output | DW | Held data word |
| dst_be | output | DW/8 | Held byte enables |
| dst_done | input | 1 | Destination finished the request |
| dst_status | input | 2 | Destination completion status |
| cfg_we | output | 1 | Local register write strobe |
| cfg_addr | output | AW | Local register write address |
| cfg_data | output | DW | Local register write data |
| cfg_be | output | DW/8 | Local register write byte enables |

## Verification
The checker assumes that org_valid is a single-cycle strobe per attempt and that dst_done is raised only while dst_req is high. It also assumes that every org_cmd value is one of the three defined codes. The stimulus keeps to these rules: it drives dst_done only after it has seen dst_req high, and it draws commands from the three legal codes alone. Attempts are repeated with exactly one field changed and are timed at both edges of the discard window, so the match and expiry rules are exercised at their limits.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_HELD  = 2'd2
  } slot_st_e;

  localparam logic [1:0] CMD_IOWR  = 2'b01;
  localparam logic [1:0] CMD_CFGL  = 2'b10;
  localparam logic [1:0] CMD_CFGF  = 2'b11;
  localparam logic [1:0] STAT_OK   = 2'b00;

  typedef struct packed {
    logic       valid;
    logic       retry;
    logic       accept;
    logic [1:0] status;
  } rsp_t;
endpackage

// File: rtl/dwr_match.sv
module dwr_match #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic [1:0]    held_cmd,
  input  logic [AW-1:0] held_addr,
  input  logic [DW-1:0] held_data,
  input  logic [BW-1:0] held_be,
  input  logic [1:0]    in_cmd,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          same
);
  always_comb begin
    same = (held_cmd == in_cmd) && (held_addr == in_addr) &&
           (held_data == in_data) && (held_be == in_be);
  end
endmodule

// File: rtl/dwr_entry.sv
module dwr_entry #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          load,
  input  logic [1:0]    in_cmd,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic [1:0]    q_cmd,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data,
  output logic [BW-1:0] q_be
);
  logic [1:0]    cmd_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;
  logic [BW-1:0] be_d;

  always_comb begin
    cmd_d  = load ? in_cmd  : q_cmd;
    addr_d = load ? in_addr : q_addr;
    data_d = load ? in_data : q_data;
    be_d   = load ? in_be   : q_be;
  end

  always_ff @(posedge clk) begin
    q_cmd  <= cmd_d;
    q_addr <= addr_d;
    q_data <= data_d;
    q_be   <= be_d;
  end
endmodule

// File: rtl/dwr_discard_timer.sv
module dwr_discard_timer #(
  parameter int LIMIT = 1024,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d  = run ? cnt_q + CW'(1) : '0;
    expire = run && (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dwr_tracker.sv
module dwr_tracker
  import dwr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DISCARD_CYCLES = 1024,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          org_valid,
  input  logic          org_near,
  input  logic [1:0]    org_cmd,
  input  logic [AW-1:0] org_addr,
  input  logic [DW-1:0] org_data,
  input  logic [BW-1:0] org_be,
  output logic          rsp_valid,
  output logic          rsp_retry,
  output logic          rsp_accept,
  output logic [1:0]    rsp_status,
  output logic          dst_req,
  output logic [1:0]    dst_cmd,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_data,
  output logic [BW-1:0] dst_be,
  input  logic          dst_done,
  input  logic [1:0]    dst_status,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_data,
  output logic [BW-1:0] cfg_be
);
  slot_st_e   st_q, st_d;
  logic       self_hit, queued, load, take, same, expire, cap_stat;
  logic [1:0] stat_q, stat_d;
  rsp_t       rsp_q, rsp_d;
  logic       cfg_we_d;
  logic [AW-1:0] cfg_addr_d;
  logic [DW-1:0] cfg_data_d;
  logic [BW-1:0] cfg_be_d;

  always_comb begin
    self_hit = org_valid && org_near && (org_cmd == CMD_CFGL);
    queued   = org_valid && !self_hit;
    load     = queued && (st_q == ST_IDLE);
    take     = queued && (st_q == ST_HELD) && same;
    cap_stat = (st_q == ST_ISSUE) && dst_done;
  end

  dwr_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk(clk), .load(load),
    .in_cmd(org_cmd), .in_addr(org_addr), .in_data(org_data), .in_be(org_be),
    .q_cmd(dst_cmd), .q_addr(dst_addr), .q_data(dst_data), .q_be(dst_be)
  );

  dwr_match #(.AW(AW), .DW(DW)) u_match (
    .held_cmd(dst_cmd), .held_addr(dst_addr), .held_data(dst_data), .held_be(dst_be),
    .in_cmd(org_cmd), .in_addr(org_addr), .in_data(org_data), .in_be(org_be),
    .same(same)
  );

  dwr_discard_timer #(.LIMIT(DISCARD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_HELD), .expire(expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (load) st_d = ST_ISSUE;
      ST_ISSUE: if (dst_done) st_d = ST_HELD;
      ST_HELD:  if (take || expire) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    stat_d = cap_stat ? dst_status : stat_q;
    rsp_d.valid  = org_valid;
    rsp_d.accept = self_hit || take;
    rsp_d.retry  = queued && !take;
    rsp_d.status = take ? stat_q : STAT_OK;
    cfg_we_d   = self_hit;
    cfg_addr_d = self_hit ? org_addr : cfg_addr;
    cfg_data_d = self_hit ? org_data : cfg_data;
    cfg_be_d   = self_hit ? org_be   : cfg_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= STAT_OK;
      rsp_q  <= '0;
      cfg_we <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      rsp_q  <= rsp_d;
      cfg_we <= cfg_we_d;
    end
  end

  always_ff @(posedge clk) begin
    cfg_addr <= cfg_addr_d;
    cfg_data <= cfg_data_d;
    cfg_be   <= cfg_be_d;
  end

  always_comb begin
    dst_req    = (st_q == ST_ISSUE);
    rsp_valid  = rsp_q.valid;
    rsp_retry  = rsp_q.retry;
    rsp_accept = rsp_q.accept;
    rsp_status = rsp_q.status;
  end
endmodule

// File: rtl/dwr_tracker_chk.sv
module dwr_tracker_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          org_valid,
  input logic          org_near,
  input logic [1:0]    org_cmd,
  input logic          rsp_valid,
  input logic          rsp_retry,
  input logic          rsp_accept,
  input logic [1:0]    rsp_status,
  input logic          dst_req,
  input logic [1:0]    dst_cmd,
  input logic [AW-1:0] dst_addr,
  input logic [DW-1:0] dst_data,
  input logic [BW-1:0] dst_be,
  input logic          dst_done,
  input logic          cfg_we
);
  logic local_cfg;
  always_comb local_cfg = org_valid && org_near && (org_cmd == 2'b10);

  assert_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    org_valid |=> rsp_valid);
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(org_valid));
  assert_single_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_retry, rsp_accept}));
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_retry && !rsp_accept));
  assert_dst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && !dst_done) |=> (dst_req && $stable(dst_cmd) && $stable(dst_addr) &&
                                $stable(dst_data) && $stable(dst_be)));
  assert_dst_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && dst_done) |=> !dst_req);
  assert_busy_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (org_valid && dst_req && !local_cfg) |=> rsp_retry);
  assert_local_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    local_cfg |=> (rsp_accept && rsp_status == 2'b00 && cfg_we));
  assert_strobe_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> rsp_accept);
endmodule

bind dwr_tracker dwr_tracker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .org_valid(org_valid), .org_near(org_near),
  .org_cmd(org_cmd), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
  .rsp_accept(rsp_accept), .rsp_status(rsp_status), .dst_req(dst_req),
  .dst_cmd(dst_cmd), .dst_addr(dst_addr), .dst_data(dst_data), .dst_be(dst_be),
  .dst_done(dst_done), .cfg_we(cfg_we)
);

// File: tb/dwr_tracker_test.sv
module dwr_tracker_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DISC = 8;

  logic clk, rst_n;
  logic org_valid, org_near, dst_done;
  logic [1:0] org_cmd, dst_status;
  logic [AW-1:0] org_addr;
  logic [DW-1:0] org_data;
  logic [BW-1:0] org_be;
  logic rsp_valid, rsp_retry, rsp_accept, dst_req, cfg_we;
  logic [1:0] rsp_status, dst_cmd;
  logic [AW-1:0] dst_addr, cfg_addr;
  logic [DW-1:0] dst_data, cfg_data;
  logic [BW-1:0] dst_be, cfg_be;

  dwr_tracker #(.AW(AW), .DW(DW), .DISCARD_CYCLES(DISC)) uut (
    .clk(clk), .rst_n(rst_n), .org_valid(org_valid), .org_near(org_near),
    .org_cmd(org_cmd), .org_addr(org_addr), .org_data(org_data), .org_be(org_be),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_accept(rsp_accept),
    .rsp_status(rsp_status), .dst_req(dst_req), .dst_cmd(dst_cmd),
    .dst_addr(dst_addr), .dst_data(dst_data), .dst_be(dst_be),
    .dst_done(dst_done), .dst_status(dst_status), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_be(cfg_be)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      report();
    end
  end

  // Behavioural reference model
  int m_st, m_cnt;
  logic [1:0] m_cmd, m_stat;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [BW-1:0] m_be;
  bit e_rv, e_ret, e_acc, e_cfg;
  logic [1:0] e_stat;
  logic [AW-1:0] e_caddr;
  logic [DW-1:0] e_cdata;
  logic [BW-1:0] e_cbe;
  bit model_live = 0;

  always @(posedge clk or negedge rst_n) begin
    int s0;
    bit took;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_stat = 0;
      e_rv = 0; e_ret = 0; e_acc = 0; e_cfg = 0; e_stat = 0;
    end else begin
      s0 = m_st;
      took = 0;
      e_rv = org_valid; e_ret = 0; e_acc = 0; e_cfg = 0; e_stat = 0;
      if (org_valid) begin
        if (org_near && org_cmd == 2'b10) begin
          e_acc = 1; e_cfg = 1;
          e_caddr = org_addr; e_cdata = org_data; e_cbe = org_be;
        end else if (s0 == 0) begin
          m_cmd = org_cmd; m_addr = org_addr; m_data = org_data; m_be = org_be;
          m_st = 1; e_ret = 1;
        end else if (s0 == 2 && org_cmd == m_cmd && org_addr == m_addr &&
                     org_data == m_data && org_be == m_be) begin
          e_acc = 1; e_stat = m_stat; m_st = 0; took = 1;
        end else begin
          e_ret = 1;
        end
      end
      if (s0 == 1 && dst_done) begin
        m_st = 2; m_stat = dst_status; m_cnt = 0;
      end else if (s0 == 2 && !took) begin
        if (m_cnt == DISC - 1) m_st = 0;
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (model_live) begin
      check(rsp_valid == e_rv, "R10 rsp_valid", 64'(rsp_valid), 64'(e_rv));
      check(rsp_retry == e_ret, "R4 rsp_retry", 64'(rsp_retry), 64'(e_ret));
      check(rsp_accept == e_acc, "R6 rsp_accept", 64'(rsp_accept), 64'(e_acc));
      if (e_acc)
        check(rsp_status == e_stat, "R3 rsp_status", 64'(rsp_status), 64'(e_stat));
      check(dst_req == (m_st == 1), "R2 dst_req", 64'(dst_req), 64'(m_st == 1));
      if (m_st == 1)
        check({dst_cmd, dst_addr, dst_data} == {m_cmd, m_addr, m_data} && dst_be == m_be,
              "R2 dst fields", {dst_cmd, dst_addr[29:0], dst_data[31:0]},
              {m_cmd, m_addr[29:0], m_data[31:0]});
      check(cfg_we == e_cfg, "R9 cfg_we", 64'(cfg_we), 64'(e_cfg));
      if (e_cfg)
        check(cfg_addr == e_caddr && cfg_data == e_cdata && cfg_be == e_cbe,
              "R9 cfg fields", {cfg_addr, cfg_data}, {e_caddr, e_cdata});
    end
  end

  task automatic attempt(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [BW-1:0] b, input bit near);
    org_valid = 1; org_cmd = c; org_addr = a; org_data = d; org_be = b; org_near = near;
    @(negedge clk); #1;
    org_valid = 0;
  endtask

  task automatic finish_dst(input logic [1:0] s);
    dst_done = 1; dst_status = s;
    @(negedge clk); #1;
    dst_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    rst_n = 0; org_valid = 0; org_near = 0; org_cmd = 2'b01; org_addr = '0;
    org_data = '0; org_be = '0; dst_done = 0; dst_status = 0;
    idle(3);
    check(!rsp_valid && !dst_req && !cfg_we, "R1 in reset", {rsp_valid, dst_req, cfg_we}, 0);
    rst_n = 1;
    model_live = 1;
    idle(1);
    check(!rsp_valid && !rsp_retry && !rsp_accept && !dst_req && !cfg_we, "R1 after reset",
          {rsp_valid, rsp_retry, rsp_accept, dst_req, cfg_we}, 0);

    // Local configuration write
    attempt(2'b10, 32'h40, 32'hCAFE_0001, 4'hF, 1);
    check(rsp_accept && cfg_we && rsp_status == 0, "R9 local write", {rsp_accept, cfg_we}, 2'b11);
    check(!dst_req, "R9 slot untouched", 64'(dst_req), 0);

    // Full delayed sequence with I/O write
    attempt(2'b01, 32'h1000, 32'h1111_2222, 4'h3, 0);
    check(rsp_retry && dst_req, "R2 first attempt", {rsp_retry, dst_req}, 2'b11);
    attempt(2'b01, 32'h1000, 32'h1111_2222, 4'h3, 0);
    check(rsp_retry, "R5 early repeat", 64'(rsp_retry), 1);
    attempt(2'b11, 32'h2000, 32'h5, 4'hF, 0);
    check(rsp_retry && dst_addr == 32'h1000, "R4 other request", dst_addr, 32'h1000);
    attempt(2'b10, 32'h44, 32'h77, 4'h1, 1);
    check(cfg_we && dst_req, "R9 local while busy", {cfg_we, dst_req}, 2'b11);
    idle(2);
    check(dst_req, "R3 held until done", 64'(dst_req), 1);
    finish_dst(2'b01);
    check(!dst_req, "R3 released", 64'(dst_req), 0);
    attempt(2'b01, 32'h1000, 32'h1111_2223, 4'h3, 0);
    check(rsp_retry, "R7 data differs", 64'(rsp_retry), 1);
    attempt(2'b01, 32'h1000, 32'h1111_2222, 4'h7, 0);
    check(rsp_retry, "R7 byte enables differ", 64'(rsp_retry), 1);
    attempt(2'b11, 32'h1000, 32'h1111_2222, 4'h3, 0);
    check(rsp_retry, "R7 command differs", 64'(rsp_retry), 1);
    attempt(2'b01, 32'h1004, 32'h1111_2222, 4'h3, 0);
    check(rsp_retry, "R7 address differs", 64'(rsp_retry), 1);
    attempt(2'b01, 32'h1000, 32'h1111_2222, 4'h3, 0);
    check(rsp_accept && rsp_status == 2'b01, "R6 matched completion",
          {rsp_accept, rsp_status}, 3'b101);
    attempt(2'b11, 32'h3000, 32'h9, 4'hF, 0);
    check(rsp_retry && dst_req && dst_addr == 32'h3000, "R6 slot freed", dst_addr, 32'h3000);

    // Discard window: last edge still accepted
    finish_dst(2'b10);
    idle(DISC - 1 - 4);
    attempt(2'b01, 32'h1, 32'h2, 4'h1, 0);
    attempt(2'b01, 32'h2, 32'h2, 4'h1, 0);
    attempt(2'b01, 32'h3, 32'h2, 4'h1, 0);
    attempt(2'b01, 32'h4, 32'h2, 4'h1, 0);
    attempt(2'b11, 32'h3000, 32'h9, 4'hF, 0);
    check(rsp_accept && rsp_status == 2'b10, "R8 last edge accepted",
          {rsp_accept, rsp_status}, 3'b110);

    // Discard window: expired
    attempt(2'b01, 32'h5000, 32'hA, 4'h2, 0);
    finish_dst(2'b00);
    idle(DISC);
    attempt(2'b01, 32'h5000, 32'hA, 4'h2, 0);
    check(rsp_retry && dst_req, "R8 entry discarded", {rsp_retry, dst_req}, 2'b11);
    finish_dst(2'b00);
    attempt(2'b01, 32'h5000, 32'hA, 4'h2, 0);
    check(rsp_accept, "R6 collect after re-issue", 64'(rsp_accept), 1);

    // Mixed traffic compared against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      org_valid = (r < 4);
      org_near = $urandom_range(0, 1);
      org_cmd = 2'($urandom_range(1, 3));
      org_addr = {30'h0, 2'($urandom_range(0, 1))} << 2;
      org_data = 32'($urandom_range(0, 1));
      org_be = $urandom_range(0, 3) == 0 ? 4'h1 : 4'hF;
      dst_done = dst_req && ($urandom_range(0, 3) == 0);
      dst_status = 2'($urandom_range(0, 2));
      @(negedge clk); #1;
    end
    org_valid = 0; dst_done = 0;
    idle(2);
    report();
  end
endmodule